// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page-mapping words for a 32-bit virtual space with 4 KB pages. It holds two kinds of entry: last-level table words, which map one page frame, and upper-level directory words, which point at a page table. A lookup presents a 20-bit virtual page number and the 12-bit page offset. One cycle later the block answers with a table hit, a directory hit or a miss. A table hit carries the cached word and the finished physical address. A directory hit carries the cached directory word, so a page walker needs only one memory read to finish the translation.

The walker writes new words through a fill port. Two flush inputs clear the storage. One of them drops every entry. The other drops only entries that are not marked global. Storage is 16 sets of 4 ways, and each set replaces with a tree pseudo-LRU.

Top module: `xlat_tlb`

## Requirements
- R1: A table entry is placed in set `vpn[3:0]` and tagged with `vpn[19:4]`. A lookup hits only on a valid table-kind entry with the same tag in that set. A lookup that differs only in the tag misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: On a table hit, `rsp_hit`=1 and `rsp_entry` is the cached word. `rsp_paddr` is `{rsp_entry[31:12], lk_off}`, where `lk_off` is the offset presented with that lookup.
- R4: A directory entry is placed in set `vpn[13:10]` and tagged with `vpn[19:14]`, zero-extended. It is looked up in parallel with the table entry. When the table lookup misses and the directory lookup hits, `rsp_dir_hit`=1, `rsp_hit`=0, `rsp_entry` is the directory word and `rsp_paddr`=0. When both lookups hit, the table entry wins and `rsp_dir_hit`=0.
- R5: On a full miss, `rsp_hit`, `rsp_dir_hit`, `rsp_entry` and `rsp_paddr` are all 0.
- R6: A fill takes the lowest-numbered invalid way of its set when one exists.
- R7: A fill into a full set evicts the pseudo-LRU victim. The tree has three bits: a root bit and one bit for each of the pairs {0,1} and {2,3}. Each bit points toward the side to evict. The tree updates on every lookup hit (table, or else directory) and on every accepted fill. When a lookup hit and a fill land in the same set in one cycle, the hit is applied first and the fill second. The victim is chosen from the state before that cycle's updates.
- R8: A fill whose kind and tag match a valid entry in its set overwrites that entry instead of taking another way.
- R9: `flush_all` invalidates every entry, global ones included.
- R10: `flush_task` invalidates every entry whose word has bit 8 (the global mark) clear, and keeps the others.
- R11: `flush_all` takes priority over `flush_task`, and either flush cancels a fill in the same cycle. A lookup in the same cycle as a fill or flush sees the contents from before that cycle.
- R12: After reset every entry is invalid, all tree bits are 0, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset carried into the physical address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Table entry hit |
| rsp_dir_hit | output | 1 | Directory entry hit with no table hit |
| rsp_entry | output | 32 | Cached word of the winning entry, else 0 |
| rsp_paddr | output | 32 | Physical address on a table hit, else 0 |
| fill_valid | input | 1 | Write one entry |
| fill_is_dir | input | 1 | Kind of the written entry: 1 directory, 0 table |
| fill_vpn | input | 20 | Page number the written entry belongs to |
| fill_entry | input | 32 | Word to cache |
| flush_all | input | 1 | Invalidate all entries |
| flush_task | input | 1 | Invalidate all non-global entries |

## Verification
Some properties are checked on every cycle. No kind-and-tag pair is ever held twice in a set. A response appears exactly one cycle after each request. A hit's physical address carries the cached frame number. After either flush, no entry of the flushed class stays valid. The tree never names the just-filled way as the next victim.

Other properties can only be shown by the bench's scenarios, compared against a behavioural model. These are which way a fill in a full set evicts, the order in which table and directory hits win, overwrite on refill, and the same-cycle rules between lookup, fill and flush.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic {
      KIND_TABLE = 1'b0,
      KIND_DIR   = 1'b1
   } xlat_kind_e;
endpackage

// File: rtl/xlat_set_match.sv
module xlat_set_match #(
   parameter int WAYS    = 4,
   parameter int TAG_W   = 16,
   parameter int ENTRY_W = 32,
   localparam int WAY_W  = $clog2(WAYS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [WAYS-1:0]                  vld,
   input  logic [WAYS-1:0]                  kind,
   input  logic [WAYS-1:0][TAG_W-1:0]       tags,
   input  logic [WAYS-1:0][ENTRY_W-1:0]     datas,
   input  xlat_pkg::xlat_kind_e             want_kind,
   input  logic [TAG_W-1:0]                 want_tag,
   output logic                             hit,
   output logic [WAY_W-1:0]                 way,
   output logic [ENTRY_W-1:0]               data
);
   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = vld[w] && (kind[w] == want_kind) && (tags[w] == want_tag);
   end

   always_comb begin
      hit  = |match;
      way  = '0;
      data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            way  = WAY_W'(w);
            data = datas[w];
         end
      end
   end

   // R8
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int LRU_W = WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_touch,
   input  logic [IDX_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_touch,
   input  logic [IDX_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAY_W-1:0] victim
);
   logic [LRU_W-1:0] lru_q [SETS];
   logic [LRU_W-1:0] lru_d [SETS];

   if (WAYS != 2 && WAYS != 4) begin : g_bad
      $error("xlat_plru supports 2 or 4 ways");
   end

   if (WAYS == 4) begin : g_tree
      function automatic logic [2:0] bump(logic [2:0] s, logic [1:0] w);
         logic [2:0] r;
         r    = s;
         r[0] = ~w[1];
         if (!w[1]) r[1] = ~w[0];
         else       r[2] = ~w[0];
         return r;
      endfunction

      function automatic logic [1:0] pick(logic [2:0] s);
         return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
      endfunction

      always_comb begin
         for (int s = 0; s < SETS; s++) lru_d[s] = lru_q[s];
         if (hit_touch)  lru_d[hit_set]  = bump(lru_d[hit_set], hit_way);
         if (fill_touch) lru_d[fill_set] = bump(lru_d[fill_set], fill_way);
      end

      assign victim = pick(lru_q[fill_set]);

      // R7
      fresh_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fill_touch |-> pick(lru_d[fill_set]) != fill_way);
   end else begin : g_pair
      always_comb begin
         for (int s = 0; s < SETS; s++) lru_d[s] = lru_q[s];
         if (hit_touch)  lru_d[hit_set]  = ~hit_way;
         if (fill_touch) lru_d[fill_set] = ~fill_way;
      end

      assign victim = lru_q[fill_set];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) lru_q[s] <= lru_d[s];
      end
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int VPN_W      = 20,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int ENTRY_W    = 32,
   parameter int OFF_W      = 12,
   parameter int DIR_BITS   = 10,
   parameter int GLOBAL_BIT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [OFF_W-1:0]   lk_off,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic               rsp_dir_hit,
   output logic [ENTRY_W-1:0] rsp_entry,
   output logic [ENTRY_W-1:0] rsp_paddr,
   input  logic               fill_valid,
   input  logic               fill_is_dir,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [ENTRY_W-1:0] fill_entry,
   input  logic               flush_all,
   input  logic               flush_task
);
   import xlat_pkg::*;

   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = VPN_W - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int DIR_LO = VPN_W - DIR_BITS;
   localparam int DTAG_W = DIR_BITS - IDX_W;

   if (SETS != (1 << IDX_W)) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (DIR_BITS <= IDX_W || DIR_BITS > VPN_W) begin : g_bad_dir
      $error("DIR_BITS must exceed the index width and fit the page number");
   end
   if (OFF_W >= ENTRY_W || GLOBAL_BIT >= OFF_W) begin : g_bad_entry
      $error("entry layout parameters out of range");
   end

   function automatic logic [IDX_W-1:0] set_of(logic [VPN_W-1:0] v, logic dir);
      return dir ? v[DIR_LO +: IDX_W] : v[IDX_W-1:0];
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(logic [VPN_W-1:0] v, logic dir);
      return dir ? TAG_W'(v[VPN_W-1 -: DTAG_W]) : v[VPN_W-1:IDX_W];
   endfunction

   logic [WAYS-1:0]                vld_q  [SETS];
   logic [WAYS-1:0]                kind_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]     tag_q  [SETS];
   logic [WAYS-1:0][ENTRY_W-1:0]   data_q [SETS];

   logic [IDX_W-1:0]   t_set, d_set, f_set;
   logic [TAG_W-1:0]   t_tag, d_tag, f_tag;
   logic               t_hit, d_hit, f_hit;
   logic [WAY_W-1:0]   t_way, d_way, f_way;
   logic [ENTRY_W-1:0] t_data, d_data, f_data_unused;
   logic               free_hit, fill_accept;
   logic [WAY_W-1:0]   free_way, victim, fill_way;
   logic               any_valid, any_local;

   assign t_set = set_of(lk_vpn, 1'b0);
   assign t_tag = tag_of(lk_vpn, 1'b0);
   assign d_set = set_of(lk_vpn, 1'b1);
   assign d_tag = tag_of(lk_vpn, 1'b1);
   assign f_set = set_of(fill_vpn, fill_is_dir);
   assign f_tag = tag_of(fill_vpn, fill_is_dir);

   xlat_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W)) u_tmatch (
      .clk(clk), .rst_n(rst_n), .vld(vld_q[t_set]), .kind(kind_q[t_set]),
      .tags(tag_q[t_set]), .datas(data_q[t_set]), .want_kind(KIND_TABLE),
      .want_tag(t_tag), .hit(t_hit), .way(t_way), .data(t_data));

   xlat_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W)) u_dmatch (
      .clk(clk), .rst_n(rst_n), .vld(vld_q[d_set]), .kind(kind_q[d_set]),
      .tags(tag_q[d_set]), .datas(data_q[d_set]), .want_kind(KIND_DIR),
      .want_tag(d_tag), .hit(d_hit), .way(d_way), .data(d_data));

   xlat_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .ENTRY_W(ENTRY_W)) u_fmatch (
      .clk(clk), .rst_n(rst_n), .vld(vld_q[f_set]), .kind(kind_q[f_set]),
      .tags(tag_q[f_set]), .datas(data_q[f_set]),
      .want_kind(fill_is_dir ? KIND_DIR : KIND_TABLE),
      .want_tag(f_tag), .hit(f_hit), .way(f_way), .data(f_data_unused));

   xlat_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk(clk), .rst_n(rst_n),
      .hit_touch(lk_valid && (t_hit || d_hit)),
      .hit_set(t_hit ? t_set : d_set),
      .hit_way(t_hit ? t_way : d_way),
      .fill_touch(fill_accept), .fill_set(f_set), .fill_way(fill_way),
      .victim(victim));

   always_comb begin
      free_hit = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_q[f_set][w]) begin
            free_hit = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   assign fill_accept = fill_valid && !flush_all && !flush_task;
   assign fill_way    = f_hit ? f_way : (free_hit ? free_way : victim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (flush_all) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (flush_task) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               if (!data_q[s][w][GLOBAL_BIT]) vld_q[s][w] <= 1'b0;
      end else if (fill_valid) begin
         vld_q[f_set][fill_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_accept) begin
         kind_q[f_set][fill_way] <= fill_is_dir;
         tag_q[f_set][fill_way]  <= f_tag;
         data_q[f_set][fill_way] <= fill_entry;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_dir_hit <= 1'b0;
         rsp_entry   <= '0;
         rsp_paddr   <= '0;
      end else begin
         rsp_valid   <= lk_valid;
         rsp_hit     <= lk_valid && t_hit;
         rsp_dir_hit <= lk_valid && !t_hit && d_hit;
         rsp_entry   <= !lk_valid ? '0 : (t_hit ? t_data : (d_hit ? d_data : '0));
         rsp_paddr   <= (lk_valid && t_hit) ? {t_data[ENTRY_W-1:OFF_W], lk_off} : '0;
      end
   end

   always_comb begin
      any_valid = 1'b0;
      any_local = 1'b0;
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) begin
            any_valid = any_valid | vld_q[s][w];
            any_local = any_local | (vld_q[s][w] & ~data_q[s][w][GLOBAL_BIT]);
         end
      end
   end

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid);
   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid);
   // R3
   paddr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_paddr[ENTRY_W-1:OFF_W] == rsp_entry[ENTRY_W-1:OFF_W]);
   // R6
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n) fill_accept |=> any_valid);
   // R9
   flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n) flush_all |=> !any_valid);
   // R10
   flush_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_task && !flush_all) |=> !any_local);
endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, fill_valid, fill_is_dir, flush_all, flush_task;
   logic [19:0] lk_vpn, fill_vpn;
   logic [11:0] lk_off;
   logic [31:0] fill_entry;
   logic        rsp_valid, rsp_hit, rsp_dir_hit;
   logic [31:0] rsp_entry, rsp_paddr;

   always #10 clk = ~clk;

   xlat_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dir_hit(rsp_dir_hit),
      .rsp_entry(rsp_entry), .rsp_paddr(rsp_paddr), .fill_valid(fill_valid),
      .fill_is_dir(fill_is_dir), .fill_vpn(fill_vpn), .fill_entry(fill_entry),
      .flush_all(flush_all), .flush_task(flush_task));

   int    checks = 0;
   int    errors = 0;
   string cur    = "R12";
   bit    done   = 0;

   task automatic check(string req, logic [71:0] act, logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // behavioural reference
   bit          mv [16][4];
   bit          md [16][4];
   logic [15:0] mt [16][4];
   logic [31:0] me [16][4];
   bit   [2:0]  ml [16];
   logic        e_valid = 0, e_hit = 0, e_dhit = 0;
   logic [31:0] e_entry = 0, e_paddr = 0;

   function automatic int vict(bit [2:0] s);
      if (s[0] == 0) return s[1] ? 1 : 0;
      return s[2] ? 3 : 2;
   endfunction

   function automatic bit [2:0] touch(bit [2:0] s, int w);
      bit [2:0] r = s;
      r[0] = (w < 2);
      if (w < 2) r[1] = (w == 0);
      else       r[2] = (w == 2);
      return r;
   endfunction

   always @(posedge clk) begin : model
      int hw, dw, fw, ts, ds, fs;
      logic [15:0] tt, dt, ft;
      if (!rst_n) begin
         foreach (mv[s, w]) mv[s][w] = 0;
         foreach (ml[s]) ml[s] = 0;
         e_valid = 0; e_hit = 0; e_dhit = 0; e_entry = 0; e_paddr = 0;
      end else begin
         ts = int'(lk_vpn[3:0]);   tt = lk_vpn[19:4];
         ds = int'(lk_vpn[13:10]); dt = {10'b0, lk_vpn[19:14]};
         hw = -1; dw = -1;
         for (int w = 0; w < 4; w++) begin
            if (mv[ts][w] && !md[ts][w] && mt[ts][w] == tt) hw = w;
            if (mv[ds][w] && md[ds][w] && mt[ds][w] == dt) dw = w;
         end
         e_valid = lk_valid;
         e_hit   = lk_valid && hw >= 0;
         e_dhit  = lk_valid && hw < 0 && dw >= 0;
         e_entry = e_hit ? me[ts][hw] : (e_dhit ? me[ds][dw] : 32'h0);
         e_paddr = e_hit ? {me[ts][hw][31:12], lk_off} : 32'h0;
         fs = fill_is_dir ? int'(fill_vpn[13:10]) : int'(fill_vpn[3:0]);
         ft = fill_is_dir ? {10'b0, fill_vpn[19:14]} : fill_vpn[19:4];
         fw = -1;
         for (int w = 0; w < 4; w++)
            if (mv[fs][w] && md[fs][w] == fill_is_dir && mt[fs][w] == ft) fw = w;
         if (fw < 0)
            for (int w = 3; w >= 0; w--) if (!mv[fs][w]) fw = w;
         if (fw < 0) fw = vict(ml[fs]);
         if (e_hit) ml[ts] = touch(ml[ts], hw);
         else if (e_dhit) ml[ds] = touch(ml[ds], dw);
         if (flush_all) begin
            foreach (mv[s, w]) mv[s][w] = 0;
         end else if (flush_task) begin
            foreach (mv[s, w]) if (!me[s][w][8]) mv[s][w] = 0;
         end else if (fill_valid) begin
            mv[fs][fw] = 1; md[fs][fw] = fill_is_dir; mt[fs][fw] = ft; me[fs][fw] = fill_entry;
            ml[fs] = touch(ml[fs], fw);
         end
      end
   end

   always @(negedge clk) begin
      if (!done)
         check(cur, {rsp_valid, rsp_hit, rsp_dir_hit, rsp_entry, rsp_paddr},
                    {e_valid, e_hit, e_dhit, e_entry, e_paddr});
   end

   task automatic lookup(input logic [19:0] v, input logic [11:0] o);
      @(negedge clk); lk_valid = 1; lk_vpn = v; lk_off = o;
      @(negedge clk); lk_valid = 0;
   endtask

   task automatic fill(input logic dir, input logic [19:0] v, input logic [31:0] e);
      @(negedge clk); fill_valid = 1; fill_is_dir = dir; fill_vpn = v; fill_entry = e;
      @(negedge clk); fill_valid = 0;
   endtask

   task automatic pulse_flush(input bit all);
      @(negedge clk); flush_all = all; flush_task = !all;
      @(negedge clk); flush_all = 0; flush_task = 0;
   endtask

   initial begin
      rst_n = 0; lk_valid = 0; lk_vpn = 0; lk_off = 0; fill_valid = 0; fill_is_dir = 0;
      fill_vpn = 0; fill_entry = 0; flush_all = 0; flush_task = 0;
      repeat (3) @(negedge clk);
      check("R12", {rsp_valid, rsp_hit, rsp_dir_hit, rsp_entry, rsp_paddr}, 72'h0);
      rst_n = 1;
      lookup(20'h12345, 12'h0);
      check("R12", {rsp_valid, rsp_hit, rsp_dir_hit}, 3'b100);

      cur = "R3";
      fill(0, 20'h12345, 32'hABCDE003);
      lookup(20'h12345, 12'h678);
      check("R3", {rsp_hit, rsp_entry, rsp_paddr}, {1'b1, 32'hABCDE003, 32'hABCDE678});
      @(negedge clk);
      check("R2", rsp_valid, 1'b0);

      cur = "R1";
      lookup(20'h22345, 12'h1);
      check("R1", {rsp_hit, rsp_dir_hit}, 2'b00);
      check("R5", {rsp_entry, rsp_paddr}, 64'h0);

      cur = "R4";
      fill(1, 20'h12345, 32'h0BEEF027);
      lookup(20'h12000, 12'h2);
      check("R4", {rsp_hit, rsp_dir_hit, rsp_entry, rsp_paddr}, {2'b01, 32'h0BEEF027, 32'h0});
      lookup(20'h12345, 12'h3);
      check("R4", {rsp_hit, rsp_dir_hit, rsp_entry}, {2'b10, 32'hABCDE003});

      cur = "R7";
      fill(0, 20'h00019, 32'hA0000000);
      fill(0, 20'h00029, 32'hB0000000);
      fill(0, 20'h00039, 32'hC0000000);
      fill(0, 20'h00049, 32'hD0000000);
      lookup(20'h00019, 12'h0);
      fill(0, 20'h00059, 32'hE0000000);
      lookup(20'h00039, 12'h0);
      check("R7", rsp_hit, 1'b0);
      lookup(20'h00019, 12'h0);
      check("R7", rsp_hit, 1'b1);

      cur = "R8";
      fill(0, 20'h00019, 32'h55555000);
      lookup(20'h00019, 12'h0);
      check("R8", {rsp_hit, rsp_entry}, {1'b1, 32'h55555000});

      cur = "R6";
      pulse_flush(1);
      fill(0, 20'h00010, 32'h10000000);
      fill(0, 20'h00020, 32'h20000000);
      lookup(20'h00010, 12'h0);
      check("R6", rsp_hit, 1'b1);
      lookup(20'h00020, 12'h0);
      check("R6", rsp_hit, 1'b1);

      cur = "R10";
      fill(0, 20'h00100, 32'h11111100);
      fill(0, 20'h00200, 32'h22222000);
      pulse_flush(0);
      lookup(20'h00100, 12'h0);
      check("R10", rsp_hit, 1'b1);
      lookup(20'h00200, 12'h0);
      check("R10", rsp_hit, 1'b0);

      cur = "R9";
      pulse_flush(1);
      lookup(20'h00100, 12'h0);
      check("R9", rsp_hit, 1'b0);

      cur = "R11";
      @(negedge clk); fill_valid = 1; fill_vpn = 20'h00300; fill_entry = 32'h33333000; flush_task = 1;
      @(negedge clk); fill_valid = 0; flush_task = 0;
      lookup(20'h00300, 12'h0);
      check("R11", rsp_hit, 1'b0);
      @(negedge clk); fill_valid = 1; fill_vpn = 20'h00400; fill_entry = 32'h44444000;
      lk_valid = 1; lk_vpn = 20'h00400; lk_off = 12'h0;
      @(negedge clk); fill_valid = 0; lk_valid = 0;
      check("R11", {rsp_valid, rsp_hit}, 2'b10);
      lookup(20'h00400, 12'h5);
      check("R11", {rsp_hit, rsp_paddr}, {1'b1, 32'h44444005});

      cur = "R7";
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         lk_valid    = 1'($urandom_range(0, 1));
         lk_vpn      = 20'(($urandom_range(0, 3) << 14) | ($urandom_range(0, 3) << 10) |
                           ($urandom_range(0, 7) << 4) | $urandom_range(0, 3));
         lk_off      = 12'($urandom());
         fill_valid  = ($urandom_range(0, 2) == 0);
         fill_is_dir = ($urandom_range(0, 3) == 0);
         fill_vpn    = 20'(($urandom_range(0, 3) << 14) | ($urandom_range(0, 3) << 10) |
                           ($urandom_range(0, 7) << 4) | $urandom_range(0, 3));
         fill_entry  = $urandom();
         flush_task  = ($urandom_range(0, 79) == 0);
         flush_all   = ($urandom_range(0, 299) == 0);
      end
      @(negedge clk);
      lk_valid = 0; fill_valid = 0; flush_task = 0; flush_all = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule